// File: doc/BRIEF.md
# DMA Channel Register File and Transfer Accounting

This block holds the software-visible state of one bus-master DMA channel that serves a SCSI protocol core. A host port addresses eight 32-bit words by a 3-bit index. Through this port software loads the initial transfer count, the physical address and the list address, and issues commands. The command word carries a two-bit opcode, a transfer direction bit and a few mode bits. A start opcode loads the programmed values into working counters, clears the status flags and raises the transfer enable.

The data path asks for transfers through a request port. Each request gives a direction and a byte length. In the same cycle the block answers with the number of bytes it grants and the memory address to use. At the next clock edge it advances its working counters. When the count runs out, or when the SCSI core reports that its command has finished, a done flag is raised. How software clears that flag depends on an external mode input: either by writing ones to the flag bits, or as a side effect of reading the status word.

Top module: `dma_chan_regs`

## Requirements
- R1: Word indices 1 (initial count), 2 (initial address) and 6 (initial list address) store the written value. Word 0 stores the whole command word. Writes to 3 (working count), 4 (working address) and 7 (working list address) are ignored. Every index reads back its stored value on `host_rdata` in the same cycle.
- R2: The command opcode is bits [1:0]. Opcode 0 drops `xfer_en`. Opcode 1 changes nothing except the stored command. Opcode 2 raises `cancel` for exactly the one cycle after the write. Opcode 3 is start.
- R3: A start copies word 1 to word 3, word 2 to word 4 and word 6 to word 7. It also clears status bits [5:0] and sets `xfer_en` at the same edge.
- R4: When `clr_by_write` is 1, a write to word 5 clears each status bit 1 (error), 2 (abort) and 3 (done) that is written as 1. Other bits are left alone.
- R5: When `clr_by_write` is 0, writes to word 5 have no effect. A read of word 5 returns the current flags, and at that edge bits 1 to 3 are cleared.
- R6: Status bit 4 is not stored. It reads as the live value of `core_irq`.
- R7: A request whose direction (`req_to_mem`, 1 = device to memory) differs from command bit 7 is refused. So is a request in the same cycle as a start. A refused request has `grant_ok` = 0 and `grant_len` = 0, and no counter changes.
- R8: An accepted request grants the smaller of `req_len` and the working count. The working count falls by the grant and the working address rises by it. Status bit 3 is set when the remaining count is 0.
- R9: `grant_addr` is the working address before the update caused by that request.
- R10: A `cmd_done` pulse forces the working count to 0 and sets status bit 3.
- R11: After reset, words 0, 1, 2, 3, 5 and 6 read 0. Word 4 reads 0xFFFFFFFF and word 7 reads 0xFFFFFFFD. `xfer_en` and `cancel` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (status read side effect) |
| host_idx | input | 3 | Word index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_idx` |
| clr_by_write | input | 1 | Status clear mode: 1 write-one-to-clear, 0 clear on read |
| core_irq | input | 1 | Live interrupt from the SCSI core |
| cmd_done | input | 1 | SCSI command finished |
| req_valid | input | 1 | Transfer request |
| req_to_mem | input | 1 | Request direction, 1 = device to memory |
| req_len | input | 32 | Requested byte count |
| grant_ok | output | 1 | Request accepted |
| grant_len | output | 32 | Granted byte count |
| grant_addr | output | 32 | Memory address for the grant |
| xfer_en | output | 1 | Transfer enable |
| cancel | output | 1 | One-cycle cancel pulse |

## Verification
The bench walks a working count down through mixed request lengths, including lengths above what remains and zero-length requests once the count is empty. A design that clamps wrongly would over-grant or wrap the count. A design that reports the updated address would be shifted by one grant. All four pairs of command direction and request direction are tried, so an inverted direction check shows up as a grant where there should be a refusal. Both status clear modes are exercised. In write-one-to-clear mode a read must not clear the flags. In clear-on-read mode a write must not clear them, and the first read must still show the done flag before the clear takes effect.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int DW  = 32;
  localparam int IW  = 3;
  localparam int SBW = 6;

  localparam logic [IW-1:0] IX_CMD   = 3'd0;
  localparam logic [IW-1:0] IX_ICNT  = 3'd1;
  localparam logic [IW-1:0] IX_IADDR = 3'd2;
  localparam logic [IW-1:0] IX_WCNT  = 3'd3;
  localparam logic [IW-1:0] IX_WADDR = 3'd4;
  localparam logic [IW-1:0] IX_STAT  = 3'd5;
  localparam logic [IW-1:0] IX_ILIST = 3'd6;
  localparam logic [IW-1:0] IX_WLIST = 3'd7;

  localparam int DIR_BIT  = 7;
  localparam int ST_ERR   = 1;
  localparam int ST_ABT   = 2;
  localparam int ST_DONE  = 3;
  localparam int ST_IRQ   = 4;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam logic [DW-1:0] WADDR_RST = {DW{1'b1}};
  localparam logic [DW-1:0] WLIST_RST = {{(DW-2){1'b1}}, 2'b01};

  function automatic logic [DW-1:0] clamp_len(input logic [DW-1:0] want,
                                              input logic [DW-1:0] left);
    return (want < left) ? want : left;
  endfunction

  function automatic logic [SBW-1:0] sticky_mask();
    logic [SBW-1:0] m;
    m = '0;
    m[ST_ERR]  = 1'b1;
    m[ST_ABT]  = 1'b1;
    m[ST_DONE] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dma_cmd_unit.sv
module dma_cmd_unit
  import dma_chan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd_q,
  output logic          start_p,
  output logic          en_q,
  output logic          cancel_q
);
  dma_op_e op;
  logic    idle_p, abort_p;

  assign op      = dma_op_e'(wdata[1:0]);
  assign start_p = cmd_wr && (op == OP_START);
  assign idle_p  = cmd_wr && (op == OP_IDLE);
  assign abort_p = cmd_wr && (op == OP_ABORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      en_q     <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= wdata;
      if (start_p)     en_q <= 1'b1;
      else if (idle_p) en_q <= 1'b0;
      cancel_q <= abort_p;
    end
  end

  AST_CANCEL_FROM_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_q |-> $past(abort_p)); // R2
  AST_ENABLE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> en_q); // R3
  AST_IDLE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    idle_p |=> !en_q); // R2
endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit
  import dma_chan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  input  logic          start_p,
  input  logic          cmd_to_mem,
  input  logic          req_valid,
  input  logic          req_to_mem,
  input  logic [DW-1:0] req_len,
  input  logic          complete,
  output logic [DW-1:0] icnt_q,
  output logic [DW-1:0] iaddr_q,
  output logic [DW-1:0] ilist_q,
  output logic [DW-1:0] wcnt_q,
  output logic [DW-1:0] waddr_q,
  output logic [DW-1:0] wlist_q,
  output logic          ok,
  output logic [DW-1:0] grant,
  output logic          done_set
);
  logic [DW-1:0] remain;

  assign ok       = req_valid && (req_to_mem == cmd_to_mem) && !start_p;
  assign grant    = ok ? clamp_len(req_len, wcnt_q) : '0;
  assign remain   = wcnt_q - grant;
  assign done_set = complete || (ok && (remain == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q  <= '0;
      iaddr_q <= '0;
      ilist_q <= '0;
      wcnt_q  <= '0;
      waddr_q <= WADDR_RST;
      wlist_q <= WLIST_RST;
    end else begin
      if (wr && idx == IX_ICNT)  icnt_q  <= wdata;
      if (wr && idx == IX_IADDR) iaddr_q <= wdata;
      if (wr && idx == IX_ILIST) ilist_q <= wdata;

      if (complete)     wcnt_q <= '0;
      else if (start_p) wcnt_q <= icnt_q;
      else if (ok)      wcnt_q <= remain;

      if (start_p)  waddr_q <= iaddr_q;
      else if (ok)  waddr_q <= waddr_q + grant;

      if (start_p) wlist_q <= ilist_q;
    end
  end

  AST_REFUSE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_to_mem != cmd_to_mem) |-> (!ok && grant == '0)); // R7
  AST_GRANT_LE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (grant <= wcnt_q)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !complete) |=> (wcnt_q == $past(wcnt_q) - $past(grant))); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> (waddr_q == $past(waddr_q) + $past(grant))); // R9
  AST_COMPLETE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (wcnt_q == '0)); // R10
  AST_START_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && !complete) |=> (wcnt_q == $past(icnt_q) && waddr_q == $past(iaddr_q))); // R3
endmodule

// File: rtl/dma_stat_unit.sv
module dma_stat_unit
  import dma_chan_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_p,
  input  logic           done_set,
  input  logic           w1c_wr,
  input  logic [SBW-1:0] w1c_bits,
  input  logic           rd_clr,
  input  logic           core_irq,
  output logic [SBW-1:0] view
);
  logic [SBW-1:0] stat_q, clr, set;

  always_comb begin
    clr = '0;
    if (start_p) clr = '1;
    if (w1c_wr)  clr = clr | (w1c_bits & sticky_mask());
    if (rd_clr)  clr = clr | sticky_mask();
    set = '0;
    set[ST_DONE] = done_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr) | set) & ~(SBW'(1) << ST_IRQ);
  end

  always_comb begin
    view = stat_q;
    view[ST_IRQ] = core_irq;
  end

  AST_W1C_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (w1c_wr && w1c_bits[ST_DONE] && !done_set) |=> !stat_q[ST_DONE]); // R4
  AST_RDCLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !done_set) |=> (stat_q[ST_DONE:ST_ERR] == '0)); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p && !done_set) |=> (stat_q == '0)); // R3
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> stat_q[ST_DONE]); // R10
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [2:0]    host_idx,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          clr_by_write,
  input  logic          core_irq,
  input  logic          cmd_done,
  input  logic          req_valid,
  input  logic          req_to_mem,
  input  logic [31:0]   req_len,
  output logic          grant_ok,
  output logic [31:0]   grant_len,
  output logic [31:0]   grant_addr,
  output logic          xfer_en,
  output logic          cancel
);
  logic [DW-1:0]  cmd_q, icnt_q, iaddr_q, ilist_q, wcnt_q, waddr_q, wlist_q;
  logic [SBW-1:0] stat_view;
  logic           start_p, done_set, stat_wr, stat_rd;

  assign stat_wr = host_wr && host_idx == IX_STAT && clr_by_write;
  assign stat_rd = host_rd && host_idx == IX_STAT && !clr_by_write;

  dma_cmd_unit u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(host_wr && host_idx == IX_CMD), .wdata(host_wdata),
    .cmd_q(cmd_q), .start_p(start_p), .en_q(xfer_en), .cancel_q(cancel)
  );

  dma_count_unit u_cnt (
    .clk(clk), .rst_n(rst_n),
    .wr(host_wr), .idx(host_idx), .wdata(host_wdata),
    .start_p(start_p), .cmd_to_mem(cmd_q[DIR_BIT]),
    .req_valid(req_valid), .req_to_mem(req_to_mem), .req_len(req_len),
    .complete(cmd_done),
    .icnt_q(icnt_q), .iaddr_q(iaddr_q), .ilist_q(ilist_q),
    .wcnt_q(wcnt_q), .waddr_q(waddr_q), .wlist_q(wlist_q),
    .ok(grant_ok), .grant(grant_len), .done_set(done_set)
  );

  dma_stat_unit u_stat (
    .clk(clk), .rst_n(rst_n),
    .start_p(start_p), .done_set(done_set),
    .w1c_wr(stat_wr), .w1c_bits(host_wdata[SBW-1:0]),
    .rd_clr(stat_rd), .core_irq(core_irq), .view(stat_view)
  );

  assign grant_addr = waddr_q;

  always_comb begin
    unique case (host_idx)
      IX_CMD:   host_rdata = cmd_q;
      IX_ICNT:  host_rdata = icnt_q;
      IX_IADDR: host_rdata = iaddr_q;
      IX_WCNT:  host_rdata = wcnt_q;
      IX_WADDR: host_rdata = waddr_q;
      IX_STAT:  host_rdata = {{(DW-SBW){1'b0}}, stat_view};
      IX_ILIST: host_rdata = ilist_q;
      default:  host_rdata = wlist_q;
    endcase
  end

  AST_STAT_IRQ_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_idx == IX_STAT) |-> (host_rdata[ST_IRQ] == core_irq)); // R6
  AST_WCNT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_idx == IX_WCNT && !start_p && !grant_ok && !cmd_done) |=> $stable(wcnt_q)); // R1
endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/100ps
module test_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 0, host_rd = 0;
  logic [2:0]  host_idx = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        clr_by_write = 1, core_irq = 0, cmd_done = 0;
  logic        req_valid = 0, req_to_mem = 0;
  logic [31:0] req_len = 0;
  logic        grant_ok, xfer_en, cancel;
  logic [31:0] grant_len, grant_addr;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .clr_by_write(clr_by_write), .core_irq(core_irq), .cmd_done(cmd_done),
    .req_valid(req_valid), .req_to_mem(req_to_mem), .req_len(req_len),
    .grant_ok(grant_ok), .grant_len(grant_len), .grant_addr(grant_addr),
    .xfer_en(xfer_en), .cancel(cancel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ix, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_idx = ix; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [2:0] ix, input logic [31:0] exp, input string tag);
    @(negedge clk);
    host_rd = 1; host_idx = ix;
    #1 chk(tag, host_rdata, exp);
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic xfer(input logic to_mem, input logic [31:0] len, input logic eok,
                      input logic [31:0] eg, input logic [31:0] ea, input string tag);
    @(negedge clk);
    req_valid = 1; req_to_mem = to_mem; req_len = len;
    #1;
    chk({tag, " ok"}, {31'd0, grant_ok}, {31'd0, eok});
    chk({tag, " len"}, grant_len, eg);
    if (eok) chk({tag, " addr R9"}, grant_addr, ea);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rem, adr, g;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset values
    rd(0, 32'h0, "R11 cmd"); rd(1, 32'h0, "R11 icnt"); rd(2, 32'h0, "R11 iaddr");
    rd(3, 32'h0, "R11 wcnt"); rd(4, 32'hFFFF_FFFF, "R11 waddr");
    rd(5, 32'h0, "R11 stat"); rd(6, 32'h0, "R11 ilist");
    rd(7, 32'hFFFF_FFFD, "R11 wlist");
    chk("R11 xfer_en", {31'd0, xfer_en}, 0); chk("R11 cancel", {31'd0, cancel}, 0);

    // R1 store and ignored writes
    wr(1, 32'h10); wr(2, 32'h1000); wr(6, 32'hABCD_0000);
    wr(3, 32'h55); wr(4, 32'h66); wr(7, 32'h77);
    rd(1, 32'h10, "R1 icnt"); rd(2, 32'h1000, "R1 iaddr"); rd(6, 32'hABCD_0000, "R1 ilist");
    rd(3, 32'h0, "R1 wcnt ignored"); rd(4, 32'hFFFF_FFFF, "R1 waddr ignored");
    rd(7, 32'hFFFF_FFFD, "R1 wlist ignored");

    // R3 start copies
    wr(0, 32'h0000_0003);
    rd(0, 32'h3, "R1 cmd readback");
    rd(3, 32'h10, "R3 wcnt"); rd(4, 32'h1000, "R3 waddr"); rd(7, 32'hABCD_0000, "R3 wlist");
    rd(5, 32'h0, "R3 stat");
    chk("R3 xfer_en", {31'd0, xfer_en}, 1);

    // R7 wrong direction
    xfer(1, 32'h4, 0, 0, 0, "R7 refuse");
    rd(3, 32'h10, "R7 wcnt unchanged");

    // R8/R9 sweep
    rem = 32'h10; adr = 32'h1000;
    for (int i = 0; i < 12; i++) begin
      logic [31:0] l;
      l = 32'((i * 3) % 7);
      g = (l < rem) ? l : rem;
      xfer(0, l, 1, g, adr, "R8 sweep");
      rem = rem - g; adr = adr + g;
      rd(3, rem, "R8 wcnt"); rd(4, adr, "R8 waddr");
    end
    rd(5, (rem == 0) ? 32'h8 : 32'h0, "R8 done flag");
    rd(5, (rem == 0) ? 32'h8 : 32'h0, "R4 read does not clear");

    // R4 write-one-to-clear
    wr(5, 32'h0); rd(5, 32'h8, "R4 write zero keeps");
    wr(5, 32'h8); rd(5, 32'h0, "R4 write one clears");

    // R6 live interrupt
    core_irq = 1; rd(5, 32'h10, "R6 irq on");
    core_irq = 0; rd(5, 32'h0, "R6 irq off");

    // R7 direction matrix
    for (int cd = 0; cd < 2; cd++) begin
      for (int rdir = 0; rdir < 2; rdir++) begin
        wr(1, 32'h8); wr(2, 32'h200);
        wr(0, (cd != 0) ? 32'h83 : 32'h03);
        xfer(rdir[0], 32'h3, (cd == rdir), (cd == rdir) ? 32'h3 : 32'h0, 32'h200, "R7 dir matrix");
        rd(3, (cd == rdir) ? 32'h5 : 32'h8, "R7 dir wcnt");
      end
    end

    // R5 clear on read
    wr(1, 32'h10); wr(2, 32'h4000); wr(0, 32'h83);
    xfer(1, 32'h20, 1, 32'h10, 32'h4000, "R8 clamp");
    clr_by_write = 0;
    wr(5, 32'h0E);
    rd(5, 32'h8, "R5 write ignored, first read");
    rd(5, 32'h0, "R5 cleared after read");
    clr_by_write = 1;

    // R10 command complete
    wr(1, 32'h40); wr(0, 32'h83);
    rd(3, 32'h40, "R10 loaded");
    @(negedge clk); cmd_done = 1; @(negedge clk); cmd_done = 0;
    rd(3, 32'h0, "R10 wcnt zero"); rd(5, 32'h8, "R10 done");

    // R2 command opcodes
    wr(0, 32'h81);
    chk("R2 blast keeps enable", {31'd0, xfer_en}, 1);
    rd(3, 32'h0, "R2 blast wcnt"); rd(5, 32'h8, "R2 blast stat");
    wr(0, 32'h82);
    chk("R2 cancel pulse", {31'd0, cancel}, 1);
    @(negedge clk);
    chk("R2 cancel one cycle", {31'd0, cancel}, 0);
    chk("R2 abort keeps enable", {31'd0, xfer_en}, 1);
    wr(0, 32'h80);
    chk("R2 idle drops enable", {31'd0, xfer_en}, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule